// File: doc/BRIEF.md
# Shared-Pool Operand Routing Datapath

This block is a small synchronous datapath made of four function units with fixed operations. The units do not talk to each other by wires. Each unit picks its two operands from a common pool of seven values: the constant zero, the constant one, the external data word, and the registered results of all four units. Every cycle, the caller supplies a separate pair of pool indices for each unit. Those index pairs decide how data moves between the units in that cycle, so a sequencer can build any chain or loop of pass, add, subtract and multiply steps one cycle at a time.

Every unit writes its result into its own register on the rising clock edge. A unit's result reaches the pool only through that register, so the index choices can never form a combinational loop. The register of unit 0 (pass-through) drives the output port. To observe any other unit, route it through unit 0 in the next cycle.

Top module: `opr_route_dp`

## Requirements
- R1: Pool index 0 supplies the constant 0. Index 1 supplies the constant 1. Index 2 supplies `data_in` as it stands in the current cycle.
- R2: Pool indices 3, 4, 5 and 6 supply the registered results of units 0, 1, 2 and 3. These are the values stored at the previous clock edge.
- R3: Pool index 7 is not a valid source and supplies zero.
- R4: Unit 0 stores its first operand unchanged. Its second select has no effect on any stored value.
- R5: Unit 1 stores first plus second operand, modulo 2^DATA_W.
- R6: Unit 2 stores first minus second operand, modulo 2^DATA_W.
- R7: Unit 3 stores the low DATA_W bits of the product of its operands.
- R8: A result computed in one cycle appears on its unit register, and therefore on the pool, one clock edge later. `data_out` is always the register of unit 0.
- R9: When `rst` is high at a rising edge, all four unit registers become zero. `rst` is active-high and synchronous.
- R10: `sel_bundle` carries 6 bits per unit. Unit u takes its first-operand index from bits [6u+2:6u] and its second-operand index from bits [6u+5:6u+3].
- R11: All four units read the same pool snapshot within a cycle. A unit that reads a register which is being overwritten at the same edge gets the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of all unit registers |
| data_in | input | DATA_W | External operand, pool index 2 |
| sel_bundle | input | 24 | Four index pairs, 3 bits per index, unit 0 in the low bits |
| data_out | output | DATA_W | Registered result of unit 0 |

## Verification
Only unit 0 is visible at the port, so a fault in any other unit stays hidden until a later cycle routes that unit's register through unit 0. A fault then shows on `data_out` two edges after the faulty computation. A wrong select decode or a wrong operation spreads into every later value that depends on it. For this reason, the bench keeps a reference copy of all four registers and compares `data_out` on every cycle. It also uses directed chains, such as a repeated add-one and a swap between units, that force the hidden registers out to the port.

// File: rtl/opr_pkg.sv
package opr_pkg;

   localparam int NUM_UNITS     = 4;
   localparam int SEL_W         = 3;
   localparam int SELS_PER_UNIT = 2;
   localparam int UNIT_SEL_W    = SEL_W * SELS_PER_UNIT;
   localparam int BUNDLE_W      = UNIT_SEL_W * NUM_UNITS;

   localparam logic [SEL_W-1:0] IDX_ZERO      = 3'd0;
   localparam logic [SEL_W-1:0] IDX_ONE       = 3'd1;
   localparam logic [SEL_W-1:0] IDX_EXT       = 3'd2;
   localparam int               IDX_UNIT_BASE = 3;
   localparam int               POOL_SIZE     = IDX_UNIT_BASE + NUM_UNITS;

   typedef enum logic [1:0] {
      OP_PASS = 2'd0,
      OP_ADD  = 2'd1,
      OP_SUB  = 2'd2,
      OP_MUL  = 2'd3
   } unit_op_e;

endpackage

// File: rtl/opr_pool_mux.sv
module opr_pool_mux
   import opr_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int N_SRC  = NUM_UNITS
) (
   input  logic [SEL_W-1:0]        sel,
   input  logic [DATA_W-1:0]       ext_val,
   input  logic [N_SRC*DATA_W-1:0] unit_q,
   output logic [DATA_W-1:0]       val
);

   localparam int LAST_IDX = IDX_UNIT_BASE + N_SRC - 1;

   if (LAST_IDX >= (1 << SEL_W)) begin : g_bad_range
      $error("opr_pool_mux: pool does not fit in the select width");
   end

   always_comb begin
      val = '0;
      if (sel == IDX_ONE) begin
         val = {{(DATA_W-1){1'b0}}, 1'b1};
      end else if (sel == IDX_EXT) begin
         val = ext_val;
      end else begin
         for (int s = 0; s < N_SRC; s++) begin
            if (int'(sel) == IDX_UNIT_BASE + s) val = unit_q[s*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/opr_alu.sv
module opr_alu
   import opr_pkg::*;
#(
   parameter int       DATA_W = 16,
   parameter unit_op_e OP     = OP_PASS
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] res
);

   if (DATA_W < 2) begin : g_bad_width
      $error("opr_alu: DATA_W must be at least 2");
   end

   if (OP == OP_ADD) begin : g_add
      assign res = opa + opb;
   end else if (OP == OP_SUB) begin : g_sub
      assign res = opa - opb;
   end else if (OP == OP_MUL) begin : g_mul
      assign res = opa * opb;
   end else begin : g_pass
      logic [DATA_W-1:0] keep_b;
      assign keep_b = opb & '0;
      assign res    = opa | keep_b;
   end

endmodule

// File: rtl/opr_unit.sv
module opr_unit
   import opr_pkg::*;
#(
   parameter int       DATA_W = 16,
   parameter int       N_SRC  = NUM_UNITS,
   parameter unit_op_e OP     = OP_PASS
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [SEL_W-1:0]        sel_a,
   input  logic [SEL_W-1:0]        sel_b,
   input  logic [DATA_W-1:0]       ext_val,
   input  logic [N_SRC*DATA_W-1:0] pool_q,
   output logic [DATA_W-1:0]       q
);

   logic [DATA_W-1:0] opa, opb, res;

   opr_pool_mux #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_mux_a (
      .sel(sel_a), .ext_val(ext_val), .unit_q(pool_q), .val(opa)
   );

   opr_pool_mux #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_mux_b (
      .sel(sel_b), .ext_val(ext_val), .unit_q(pool_q), .val(opb)
   );

   opr_alu #(.DATA_W(DATA_W), .OP(OP)) u_alu (
      .opa(opa), .opb(opb), .res(res)
   );

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= res;
   end

   // R9: one edge after reset was sampled high, the register must read zero
   logic rst_seen;
   always_ff @(posedge clk) rst_seen <= rst;

   always_ff @(posedge clk) begin
      if (rst_seen) begin
         assert_reset_clears_R9: assert (q == '0)
            else $error("unit register not cleared by reset");
      end
   end

endmodule

// File: rtl/opr_route_dp.sv
module opr_route_dp
   import opr_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [DATA_W-1:0]   data_in,
   input  logic [BUNDLE_W-1:0] sel_bundle,
   output logic [DATA_W-1:0]   data_out
);

   logic [NUM_UNITS*DATA_W-1:0] pool_q;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      opr_unit #(
         .DATA_W(DATA_W),
         .N_SRC (NUM_UNITS),
         .OP    (unit_op_e'(u))
      ) u_unit (
         .clk    (clk),
         .rst    (rst),
         .sel_a  (sel_bundle[u*UNIT_SEL_W +: SEL_W]),
         .sel_b  (sel_bundle[u*UNIT_SEL_W + SEL_W +: SEL_W]),
         .ext_val(data_in),
         .pool_q (pool_q),
         .q      (pool_q[u*DATA_W +: DATA_W])
      );
   end

   assign data_out = pool_q[0 +: DATA_W];

   // Port-level checks on unit 0 routing
   logic [SEL_W-1:0] u0_a;
   assign u0_a = sel_bundle[SEL_W-1:0];

   // R1 and R8: external input through unit 0 arrives one edge later
   assert_ext_pass_R1: assert property (@(posedge clk) disable iff (rst)
      (u0_a == IDX_EXT) |=> (data_out == $past(data_in)));

   // R1: constant one
   assert_const_one_R1: assert property (@(posedge clk) disable iff (rst)
      (u0_a == IDX_ONE) |=> (data_out == DATA_W'(1)));

   // R3: index 7 and index 0 both give zero
   assert_idx7_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (u0_a == 3'd7 || u0_a == IDX_ZERO) |=> (data_out == '0));

   // R2 and R4: unit 0 selecting its own register holds its value
   assert_self_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (u0_a == 3'(IDX_UNIT_BASE)) |=> $stable(data_out));

   // R11: unit 0 taking unit 1's register sees the value from before the edge
   assert_old_snapshot_R11: assert property (@(posedge clk) disable iff (rst)
      (u0_a == 3'(IDX_UNIT_BASE + 1)) |=>
         (data_out == $past(pool_q[DATA_W +: DATA_W])));

endmodule

// File: tb/opr_route_dp_tb.sv
`timescale 1ns/1ps
module opr_route_dp_tb;

   localparam int W  = 16;
   localparam int NU = 4;
   localparam int BW = 24;

   logic          clk = 1'b0;
   logic          rst;
   logic [W-1:0]  data_in;
   logic [BW-1:0] sel_bundle;
   logic [W-1:0]  data_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [NU*W-1:0] mdl;

   always #10 clk = ~clk;

   opr_route_dp #(.DATA_W(W)) u_dut (
      .clk(clk), .rst(rst), .data_in(data_in),
      .sel_bundle(sel_bundle), .data_out(data_out)
   );

   function automatic logic [BW-1:0] mk(input int a0, b0, a1, b1, a2, b2, a3, b3);
      mk = {3'(b3), 3'(a3), 3'(b2), 3'(a2), 3'(b1), 3'(a1), 3'(b0), 3'(a0)};
   endfunction

   function automatic logic [W-1:0] pick(input logic [2:0] s, input logic [W-1:0] d,
                                         input logic [NU*W-1:0] cur);
      case (s)
         3'd0: pick = '0;
         3'd1: pick = W'(1);
         3'd2: pick = d;
         3'd3, 3'd4, 3'd5, 3'd6: pick = cur[(int'(s)-3)*W +: W];
         default: pick = '0;
      endcase
   endfunction

   function automatic logic [NU*W-1:0] next_regs(input logic [BW-1:0] b, input logic [W-1:0] d,
                                                 input logic [NU*W-1:0] cur);
      logic [W-1:0] x, y;
      for (int u = 0; u < NU; u++) begin
         x = pick(b[u*6 +: 3], d, cur);
         y = pick(b[u*6+3 +: 3], d, cur);
         case (u)
            0: next_regs[u*W +: W] = x;
            1: next_regs[u*W +: W] = x + y;
            2: next_regs[u*W +: W] = x - y;
            default: next_regs[u*W +: W] = W'((32'(x) * 32'(y)) & 32'hFFFF);
         endcase
      end
   endfunction

   task automatic check(input string tag, input logic [W-1:0] exp);
      n_chk++;
      if (data_out !== exp) begin
         n_fail++;
         $display("FAIL %s: data_out=%h expected=%h", tag, data_out, exp);
      end
   endtask

   // inputs change just after a falling edge; output sampled at the next falling edge
   task automatic step(input logic [BW-1:0] b, input logic [W-1:0] d, input string tag, input bit chk);
      sel_bundle = b;
      data_in    = d;
      mdl        = next_regs(b, d, mdl);
      @(negedge clk);
      if (chk) check(tag, mdl[0 +: W]);
   endtask

   task automatic do_reset(input string tag);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      mdl = '0;
      check(tag, '0);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst = 1'b1;
      data_in = '0;
      sel_bundle = '0;
      mdl = '0;
      @(negedge clk);
      do_reset("R9 reset state");

      // R1: constants and external input through unit 0
      step(mk(2,0, 0,0, 0,0, 0,0), 16'h1234, "R1 ext", 1);
      step(mk(1,0, 0,0, 0,0, 0,0), 16'h0000, "R1 one", 1);
      step(mk(0,0, 0,0, 0,0, 0,0), 16'hBEEF, "R1 zero", 1);
      // R3: invalid index
      step(mk(2,0, 0,0, 0,0, 0,0), 16'hAAAA, "R3 setup", 1);
      step(mk(7,2, 0,0, 0,0, 0,0), 16'h5555, "R3 idx7", 1);
      // R4: second select ignored
      step(mk(2,1, 0,0, 0,0, 0,0), 16'h0F0F, "R4 b=1", 1);
      step(mk(2,6, 0,0, 0,0, 0,0), 16'h0F0F, "R4 b=6", 1);
      step(mk(3,2, 0,0, 0,0, 0,0), 16'h7777, "R4 hold", 1);

      // R5: add wraps
      step(mk(3,0, 2,1, 0,0, 0,0), 16'hFFFF, "R5 load", 1);
      step(mk(4,0, 4,1, 0,0, 0,0), 16'h0000, "R5 wrap", 1);
      if (data_out !== 16'h0000) $display("FAIL R5 direct: data_out=%h expected=0000", data_out);
      // R8: repeated add-one chain
      for (int i = 0; i < 6; i++) step(mk(4,0, 4,1, 0,0, 0,0), '0, "R8 chain", 1);

      // R6: subtract wraps
      step(mk(3,0, 0,0, 0,1, 0,0), 16'h0000, "R6 load", 1);
      step(mk(5,0, 0,0, 0,0, 0,0), 16'h0000, "R6 0-1", 1);
      step(mk(3,0, 0,0, 2,5, 0,0), 16'h0005, "R6 order", 1);
      step(mk(5,0, 0,0, 0,0, 0,0), 16'h0000, "R6 view", 1);

      // R7: multiply keeps low half
      step(mk(3,0, 0,0, 0,0, 2,2), 16'h1234, "R7 load", 1);
      step(mk(6,0, 0,0, 0,0, 6,2), 16'h0003, "R7 view", 1);
      step(mk(6,0, 0,0, 0,0, 0,0), 16'h0000, "R7 feedback", 1);

      // R10 and R11: swap through the pool at one edge
      step(mk(2,0, 2,0, 0,0, 0,0), 16'h00A1, "R10 load", 1);
      step(mk(4,0, 3,0, 0,0, 0,0), 16'h0000, "R11 swap", 1);
      step(mk(4,0, 0,0, 0,0, 0,0), 16'h0000, "R11 old value", 1);

      // R9: reset in mid-run clears the hidden registers
      step(mk(2,0, 2,1, 2,0, 2,2), 16'h0101, "R9 prefill", 1);
      do_reset("R9 mid-run");
      step(mk(4,0, 0,0, 0,0, 0,0), 16'hFFFF, "R9 unit1", 1);
      step(mk(5,0, 0,0, 0,0, 0,0), 16'hFFFF, "R9 unit2", 1);
      step(mk(6,0, 0,0, 0,0, 0,0), 16'hFFFF, "R9 unit3", 1);

      // R2 and R8: random routing against the model
      for (int i = 0; i < 3000; i++) begin
         step(BW'($urandom), W'($urandom), "R2 random", 1);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule